// File: doc/BRIEF.md
# Boot-Persistent Event Mode Selector

This block decides whether platform events go out on the legacy event path or on the exposed interrupt path. It holds two retained bits. The pending mode collects what the running software claims during the current boot. The effective mode is the one that actually steers events. Both bits model non-volatile storage, so only the power-on reset clears them. A boot pulse marks the start of every new boot.

During a boot, software shows that it supports the exposed interrupt mode by issuing a request strobe. The strobe carries a function index, a revision and an argument, and only the exact value triple counts. A change of mode never takes effect inside the boot that asked for it. Every boot pulse copies the pending mode into the effective mode and then sets the pending mode back to legacy. Software therefore has to claim support again on every boot. If it stops doing so, the platform stays in exposed mode for one more boot and returns to legacy only at the second boot pulse.

The effective mode gates an event vector onto exactly one of the two output paths. A status output reports both retained bits.

Top module: `evmode_selector`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both pending and effective mode become legacy. `mode_status` reads 2'b00 on the next sample.
- R2: A request counts as valid only when `req_valid` is 1 and `req_func`, `req_rev` and `req_arg` are all equal to 1. A valid request outside a boot pulse sets the pending mode to exposed at the next clock edge and leaves the effective mode unchanged.
- R3: The effective mode changes only at a clock edge where `boot_pulse` is 1. At that edge it takes the value the pending mode held just before the edge.
- R4: At a boot pulse the pending mode becomes legacy, unless a valid request arrives in the same cycle. In that case the pending mode becomes exposed, and the request counts toward the boot that is starting.
- R5: Support does not carry over between boots. Suppose the effective mode is exposed and no valid request arrives after the boot pulse that last loaded exposed. The effective mode then becomes legacy at the next boot pulse, which is the second boot pulse after the last request.
- R6: A request with `req_valid` at 0, or with any of the three fields not equal to 1, changes neither mode.
- R7: While the effective mode is legacy, `evt_legacy` equals `evt_in` and `evt_exposed` is zero. While it is exposed, `evt_exposed` equals `evt_in` and `evt_legacy` is zero. This holds in the same cycle as the input.
- R8: `mode_status[1]` shows the pending mode and `mode_status[0]` shows the effective mode. `mode_exposed` equals `mode_status[0]`. In every bit, 1 means exposed and 0 means legacy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; clears the retained modes |
| boot_pulse | input | 1 | One-cycle mark at the start of each boot |
| req_valid | input | 1 | Support request strobe |
| req_func | input | FIELD_W | Function index carried by the request |
| req_rev | input | FIELD_W | Revision carried by the request |
| req_arg | input | FIELD_W | Enable argument carried by the request |
| evt_in | input | EVT_W | Incoming events |
| evt_legacy | output | EVT_W | Events delivered on the legacy path |
| evt_exposed | output | EVT_W | Events delivered on the exposed interrupt path |
| mode_exposed | output | 1 | Effective mode, 1 = exposed |
| mode_status | output | 2 | {pending, effective} mode bits |

## Verification
Both mode bits are registers. A request, boot pulse or reset driven in one cycle therefore shows up on `mode_status` and `mode_exposed` one rising edge later. The routing outputs follow `evt_in` in the same cycle, and follow a mode change as soon as that change is registered. The bench drives inputs on the falling edge and samples shortly after the next falling edge. By then exactly one rising edge has passed, and both the registered results and the combinational results have settled. A behavioural model advances on the same rising edge and is compared on every cycle. The directed sequences additionally check fixed status values at each step of the one-boot delay and the two-boot fallback.

// File: rtl/evmode_pkg.sv
// Package: shared types for the event mode selector.
// Assumes a single-bit mode encoding, where 1 means the exposed interrupt path.
package evmode_pkg;

    typedef enum logic {
        MODE_LEGACY  = 1'b0,
        MODE_EXPOSED = 1'b1
    } evmode_e;

    typedef struct packed {
        evmode_e pending;
        evmode_e effective;
    } evmode_status_t;

endpackage

// File: rtl/evmode_req_decode.sv
// Module: qualifies a support request by matching all three fields exactly.
// Assumes the fields are stable for the cycle in which req_valid is high.
module evmode_req_decode #(
    parameter int              FIELD_W  = 8,
    parameter logic [FIELD_W-1:0] FUNC_ID = 1,
    parameter logic [FIELD_W-1:0] REV_ID  = 1,
    parameter logic [FIELD_W-1:0] ARG_ON  = 1
) (
    input  logic               req_valid,
    input  logic [FIELD_W-1:0] req_func,
    input  logic [FIELD_W-1:0] req_rev,
    input  logic [FIELD_W-1:0] req_arg,
    output logic               req_hit
);

    logic func_ok, rev_ok, arg_ok;

    // Purpose: compare each field against its expected constant.
    always_comb begin
        func_ok = (req_func == FUNC_ID);
        rev_ok  = (req_rev  == REV_ID);
        arg_ok  = (req_arg  == ARG_ON);
        req_hit = req_valid && func_ok && rev_ok && arg_ok;
    end

endmodule

// File: rtl/evmode_state.sv
// Module: retained pending and effective mode registers.
// Assumes that rst_n is only the power-on reset, since the registers model non-volatile bits.
// A boot pulse moves pending into effective and re-arms pending to legacy.
// A hit in the same cycle counts toward the new boot.
module evmode_state
    import evmode_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    boot_pulse,
    input  logic    req_hit,
    output evmode_e pend_mode,
    output evmode_e eff_mode
);

    evmode_e pend_q, eff_q;

    // Purpose: update the effective mode, only at a boot pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eff_q <= MODE_LEGACY;
        else if (boot_pulse)
            eff_q <= pend_q;
    end

    // Purpose: collect support claims for the current boot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= MODE_LEGACY;
        else if (req_hit)
            pend_q <= MODE_EXPOSED;
        else if (boot_pulse)
            pend_q <= MODE_LEGACY;
    end

    assign pend_mode = pend_q;
    assign eff_mode  = eff_q;

    a_r1_reset_legacy: assert property (@(posedge clk)
        $past(!rst_n) |-> (pend_q == MODE_LEGACY && eff_q == MODE_LEGACY));

    a_r3_eff_only_on_boot: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_pulse |=> $stable(eff_q));

    a_r3_boot_loads_pending: assert property (@(posedge clk) disable iff (!rst_n)
        boot_pulse |=> (eff_q == $past(pend_q)));

    a_r2_hit_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit |=> (pend_q == MODE_EXPOSED));

    a_r4_boot_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_pulse && !req_hit) |=> (pend_q == MODE_LEGACY));

    a_r6_idle_holds_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_pulse && !req_hit) |=> $stable(pend_q));

endmodule

// File: rtl/evmode_route.sv
// Module: steers each event bit to exactly one path according to the effective mode.
// Assumes the mode input is a registered signal, so the path is purely combinational.
module evmode_route
    import evmode_pkg::*;
#(
    parameter int EVT_W = 16
) (
    input  evmode_e          eff_mode,
    input  logic [EVT_W-1:0] evt_in,
    output logic [EVT_W-1:0] evt_legacy,
    output logic [EVT_W-1:0] evt_exposed
);

    logic sel_exp;
    assign sel_exp = (eff_mode == MODE_EXPOSED);

    for (genvar g = 0; g < EVT_W; g++) begin : g_lane
        // Purpose: gate one event lane onto the selected path.
        always_comb begin
            evt_legacy[g]  = evt_in[g] & ~sel_exp;
            evt_exposed[g] = evt_in[g] &  sel_exp;
        end
    end

endmodule

// File: rtl/evmode_selector.sv
// Module: top level of the boot-persistent event mode selector.
// Assumes boot_pulse is high for one cycle per boot and rst_n is the synchronous power-on reset.
module evmode_selector
    import evmode_pkg::*;
#(
    parameter int                 EVT_W   = 16,
    parameter int                 FIELD_W = 8,
    parameter logic [FIELD_W-1:0] FUNC_ID = 1,
    parameter logic [FIELD_W-1:0] REV_ID  = 1,
    parameter logic [FIELD_W-1:0] ARG_ON  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_pulse,
    input  logic               req_valid,
    input  logic [FIELD_W-1:0] req_func,
    input  logic [FIELD_W-1:0] req_rev,
    input  logic [FIELD_W-1:0] req_arg,
    input  logic [EVT_W-1:0]   evt_in,
    output logic [EVT_W-1:0]   evt_legacy,
    output logic [EVT_W-1:0]   evt_exposed,
    output logic               mode_exposed,
    output logic [1:0]         mode_status
);

    logic           req_hit;
    evmode_e        pend_mode, eff_mode;
    evmode_status_t status_w;

    evmode_req_decode #(
        .FIELD_W (FIELD_W),
        .FUNC_ID (FUNC_ID),
        .REV_ID  (REV_ID),
        .ARG_ON  (ARG_ON)
    ) i_decode (
        .req_valid (req_valid),
        .req_func  (req_func),
        .req_rev   (req_rev),
        .req_arg   (req_arg),
        .req_hit   (req_hit)
    );

    evmode_state i_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_pulse (boot_pulse),
        .req_hit    (req_hit),
        .pend_mode  (pend_mode),
        .eff_mode   (eff_mode)
    );

    evmode_route #(
        .EVT_W (EVT_W)
    ) i_route (
        .eff_mode    (eff_mode),
        .evt_in      (evt_in),
        .evt_legacy  (evt_legacy),
        .evt_exposed (evt_exposed)
    );

    // Purpose: pack the retained bits into the read-only status word.
    always_comb begin
        status_w.pending   = pend_mode;
        status_w.effective = eff_mode;
    end

    assign mode_status  = status_w;
    assign mode_exposed = (eff_mode == MODE_EXPOSED);

    a_r6_bad_request_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_func != FUNC_ID || req_rev != REV_ID || req_arg != ARG_ON))
            |-> !req_hit);

    a_r7_legacy_silent_when_exposed: assert property (@(posedge clk) disable iff (!rst_n)
        mode_exposed |-> (evt_legacy == '0 && evt_exposed == evt_in));

    a_r7_exposed_silent_when_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_exposed |-> (evt_exposed == '0 && evt_legacy == evt_in));

    a_r8_paths_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_legacy & evt_exposed) == '0);

endmodule

// File: tb/test_evmode_selector.sv
module test_evmode_selector;

    localparam int EW = 16;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          boot_pulse = 1'b0;
    logic          req_valid = 1'b0;
    logic [FW-1:0] req_func = '0;
    logic [FW-1:0] req_rev = '0;
    logic [FW-1:0] req_arg = '0;
    logic [EW-1:0] evt_in = '0;
    logic [EW-1:0] evt_legacy, evt_exposed;
    logic          mode_exposed;
    logic [1:0]    mode_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state: 1 = exposed
    int m_pend = 0;
    int m_eff  = 0;

    always #5 clk = ~clk;

    evmode_selector #(.EVT_W(EW), .FIELD_W(FW)) i_evmode_selector (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_pulse   (boot_pulse),
        .req_valid    (req_valid),
        .req_func     (req_func),
        .req_rev      (req_rev),
        .req_arg      (req_arg),
        .evt_in       (evt_in),
        .evt_legacy   (evt_legacy),
        .evt_exposed  (evt_exposed),
        .mode_exposed (mode_exposed),
        .mode_status  (mode_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model: the support claim for a boot is judged from the inputs at the edge
    always @(posedge clk) begin
        bit claim;
        claim = req_valid && req_func == 1 && req_rev == 1 && req_arg == 1;
        if (!rst_n) begin
            m_pend = 0; m_eff = 0;
        end else begin
            if (boot_pulse) m_eff = m_pend;
            if (claim) m_pend = 1;
            else if (boot_pulse) m_pend = 0;
        end
    end

    // event stimulus changes every cycle
    always @(negedge clk) evt_in <= EW'($urandom);

    // per-cycle comparison against the model (R7, R8)
    always begin
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            chk("R8 status", {30'd0, mode_status}, {30'd0, 1'(m_pend), 1'(m_eff)});
            chk("R8 mode_exposed", {31'd0, mode_exposed}, 32'(m_eff));
            chk("R7 legacy path", 32'(evt_legacy), m_eff != 0 ? 32'd0 : 32'(evt_in));
            chk("R7 exposed path", 32'(evt_exposed), m_eff != 0 ? 32'(evt_in) : 32'd0);
        end
    end

    // one cycle of stimulus, then sample after the edge
    task automatic step(input bit boot, input bit v, input int f, input int r, input int a);
        @(negedge clk);
        boot_pulse = boot; req_valid = v;
        req_func = FW'(f); req_rev = FW'(r); req_arg = FW'(a);
        @(negedge clk);
        boot_pulse = 1'b0; req_valid = 1'b0;
        req_func = '0; req_rev = '0; req_arg = '0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset status", 32'(mode_status), 32'h0);
        chk("R1 reset exposed path", 32'(evt_exposed), 32'h0);

        step(1, 0, 0, 0, 0);
        chk("R3 boot without claim", 32'(mode_status), 32'h0);

        // malformed requests (R6)
        step(0, 1, 2, 1, 1);
        chk("R6 wrong function", 32'(mode_status), 32'h0);
        step(0, 1, 1, 0, 1);
        chk("R6 wrong revision", 32'(mode_status), 32'h0);
        step(0, 1, 1, 1, 0);
        chk("R6 wrong argument", 32'(mode_status), 32'h0);
        step(0, 0, 1, 1, 1);
        chk("R6 valid low", 32'(mode_status), 32'h0);

        // claim, then take effect at next boot (R2, R3)
        step(0, 1, 1, 1, 1);
        chk("R2 claim sets pending only", 32'(mode_status), 32'h2);
        step(0, 0, 0, 0, 0);
        chk("R3 no boot keeps effective", 32'(mode_status), 32'h2);
        step(1, 0, 0, 0, 0);
        chk("R3 boot loads exposed", 32'(mode_status), 32'h1);
        chk("R7 legacy silent", 32'(evt_legacy), 32'h0);

        // claimed again, then dropped: two-boot fallback (R5)
        step(0, 1, 1, 1, 1);
        chk("R2 re-claim", 32'(mode_status), 32'h3);
        step(1, 0, 0, 0, 0);
        chk("R5 still exposed after boot", 32'(mode_status), 32'h1);
        step(0, 1, 7, 1, 1);
        chk("R6 bad claim while exposed", 32'(mode_status), 32'h1);
        step(1, 0, 0, 0, 0);
        chk("R5 legacy at second boot", 32'(mode_status), 32'h0);

        // claim in the same cycle as the boot pulse (R4)
        step(0, 1, 1, 1, 1);
        chk("R2 claim before boot", 32'(mode_status), 32'h2);
        step(1, 1, 1, 1, 1);
        chk("R4 claim with boot", 32'(mode_status), 32'h3);
        step(1, 0, 0, 0, 0);
        chk("R4 rearm to legacy", 32'(mode_status), 32'h1);
        step(1, 1, 1, 1, 0);
        chk("R4 bad claim with boot", 32'(mode_status), 32'h0);

        // reset while exposed (R1)
        step(1, 1, 1, 1, 1);
        step(1, 0, 0, 0, 0);
        chk("R1 exposed before reset", 32'(mode_status), 32'h1);
        do_reset();
        chk("R1 reset clears retained", 32'(mode_status), 32'h0);

        // random traffic checked by the model
        for (int i = 0; i < 400; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            step(k < 3, k >= 2, (k == 5) ? 3 : 1, (k == 6) ? 2 : 1, (k == 7) ? 0 : 1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule